// File: doc/BRIEF.md
# Shift-Rotate Register Through Carry

This block is a clocked register of parameterised width (8 bits by default) with a single carry bit beside it. On a qualified clock edge it does one of five things. It can take a parallel word. It can shift left, moving the top bit into carry. It can rotate left through the carry bit. It can rotate right, wrapping the low bit straight into the top bit. It can shift right with a zero fill. Each of these actions costs exactly one qualified clock edge. When no edge is qualified, the register holds.

A separate active-low clear input forces carry to zero on the next clock edge. It overrides any carry value that a left move would produce. The two directions are deliberately asymmetric. Left moves always route through the carry bit. Right moves never touch carry.

Top module: `shreg_carry_reg`

## Requirements
- R1: While rst_ni is low, data_o reads 0 and carry_o reads 0.
- R2: On an edge with pulse_i = 0, data_o keeps its value whatever the other inputs do (carry is only affected per R8).
- R3: On an edge with pulse_i = 1 and step_en_i = 0, data_o takes load_data_i.
- R4: On an edge with pulse_i = 1, step_en_i = 1, dir_right_i = 0, rotate_i = 0, data_o becomes its old value shifted left by one with bit 0 = 0, and carry_o takes the old top bit.
- R5: On an edge with pulse_i = 1, step_en_i = 1, dir_right_i = 0, rotate_i = 1, data_o becomes its old value shifted left by one with bit 0 = old carry_o, and carry_o takes the old top bit.
- R6: On an edge with pulse_i = 1, step_en_i = 1, dir_right_i = 1, rotate_i = 1, data_o becomes its old value shifted right by one with the top bit = old bit 0, and carry_o is unchanged.
- R7: On an edge with pulse_i = 1, step_en_i = 1, dir_right_i = 1, rotate_i = 0, data_o becomes its old value shifted right by one with the top bit = 0, and carry_o is unchanged.
- R8: On any edge with carry_clr_ni = 0, carry_o becomes 0. This includes hold edges, and it takes precedence over the carry update of R4 and R5.
- R9: With carry_clr_ni = 1, a load (R3) or a hold (R2) leaves carry_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Qualifies the edge as an action; 0 holds the register |
| step_en_i | input | 1 | 1 selects shift/rotate, 0 selects parallel load |
| dir_right_i | input | 1 | 1 moves right, 0 moves left |
| rotate_i | input | 1 | 1 selects rotate, 0 selects logical shift |
| carry_clr_ni | input | 1 | Clears carry on the edge, active low |
| load_data_i | input | WIDTH | Parallel load word |
| data_o | output | WIDTH | Register contents |
| carry_o | output | 1 | Carry bit |

## Verification
The embedded properties assume two things. All control inputs are known at every clock edge, and reset has been asserted once before the first action. Each property then compares the present outputs with the previous outputs and the previous controls. The bench applies reset first and changes inputs only on the falling clock edge, so every sampled control value is stable and defined. It sweeps every 8-bit value through every action with both carry starting states.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_SHL,
    OP_ROL,
    OP_SHR,
    OP_ROR
  } shreg_op_e;
endpackage

// File: rtl/shreg_decode.sv
module shreg_decode
  import shreg_pkg::*;
(
  input  logic      pulse_i,
  input  logic      step_en_i,
  input  logic      dir_right_i,
  input  logic      rotate_i,
  output shreg_op_e op_o
);
  always_comb begin
    if (!pulse_i)        op_o = OP_HOLD;
    else if (!step_en_i) op_o = OP_LOAD;
    else begin
      unique case ({dir_right_i, rotate_i})
        2'b00:   op_o = OP_SHL;
        2'b01:   op_o = OP_ROL;
        2'b10:   op_o = OP_SHR;
        default: op_o = OP_ROR;
      endcase
    end
  end
endmodule

// File: rtl/shreg_datapath.sv
module shreg_datapath
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  shreg_op_e        op_i,
  input  logic [WIDTH-1:0] data_q_i,
  input  logic             carry_q_i,
  input  logic [WIDTH-1:0] load_i,
  input  logic             carry_clr_ni,
  output logic [WIDTH-1:0] data_d_o,
  output logic             carry_d_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] left_v, right_v;
  logic             fill_left, fill_right;

  assign fill_left  = (op_i == OP_ROL) ? carry_q_i : 1'b0;
  assign fill_right = (op_i == OP_ROR) ? data_q_i[0] : 1'b0;

  // per-bit neighbour wiring for both directions
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign left_v[i] = fill_left;
    end else begin : g_lo_n
      assign left_v[i] = data_q_i[i-1];
    end
    if (i == MSB) begin : g_hi
      assign right_v[i] = fill_right;
    end else begin : g_hi_n
      assign right_v[i] = data_q_i[i+1];
    end
  end

  always_comb begin
    data_d_o  = data_q_i;
    carry_d_o = carry_q_i;
    unique case (op_i)
      OP_LOAD:        data_d_o = load_i;
      OP_SHL, OP_ROL: begin
        data_d_o  = left_v;
        carry_d_o = data_q_i[MSB];
      end
      OP_SHR, OP_ROR: data_d_o = right_v;
      default: ;
    endcase
    if (!carry_clr_ni) carry_d_o = 1'b0;  // clear wins
  end
endmodule

// File: rtl/shreg_carry_reg.sv
module shreg_carry_reg
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             step_en_i,
  input  logic             dir_right_i,
  input  logic             rotate_i,
  input  logic             carry_clr_ni,
  input  logic [WIDTH-1:0] load_data_i,
  output logic [WIDTH-1:0] data_o,
  output logic             carry_o
);
  localparam int MSB = WIDTH - 1;

  shreg_op_e        op;
  logic [WIDTH-1:0] data_q, data_d;
  logic             carry_q, carry_d;

  shreg_decode u_decode (
    .pulse_i    (pulse_i),
    .step_en_i  (step_en_i),
    .dir_right_i(dir_right_i),
    .rotate_i   (rotate_i),
    .op_o       (op)
  );

  shreg_datapath #(.WIDTH(WIDTH)) u_dp (
    .op_i        (op),
    .data_q_i    (data_q),
    .carry_q_i   (carry_q),
    .load_i      (load_data_i),
    .carry_clr_ni(carry_clr_ni),
    .data_d_o    (data_d),
    .carry_d_o   (carry_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      carry_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      carry_q <= carry_d;
    end
  end

  assign data_o  = data_q;
  assign carry_o = carry_q;

  always_comb begin
    if (!rst_ni) a_r1_reset_zero: assert (data_o == '0 && carry_o == 1'b0);
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> data_o == $past(data_o));

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !step_en_i) |=> data_o == $past(load_data_i));

  a_r5_rol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && step_en_i && !dir_right_i && rotate_i && carry_clr_ni) |=>
      (data_o == {$past(data_o[MSB-1:0]), $past(carry_o)}) && (carry_o == $past(data_o[MSB])));

  a_r6_ror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && step_en_i && dir_right_i && rotate_i && carry_clr_ni) |=>
      (data_o == {$past(data_o[0]), $past(data_o[MSB:1])}) && $stable(carry_o));

  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_clr_ni |=> !carry_o);
endmodule

// File: tb/sim_shreg_carry_reg.sv
module sim_shreg_carry_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse = 1'b0, step = 1'b0, dir = 1'b0, rot = 1'b0, clr_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic         cout;

  int n_run = 0, n_fail = 0;
  logic [W-1:0] m_d = '0;
  logic         m_c = 1'b0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  shreg_carry_reg #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .step_en_i(step),
    .dir_right_i(dir), .rotate_i(rot), .carry_clr_ni(clr_n),
    .load_data_i(din), .data_o(dout), .carry_o(cout)
  );

  task automatic check(input string tag);
    n_run++;
    if (dout !== m_d || cout !== m_c) begin
      n_fail++;
      $display("FAIL %s: data=%h carry=%b expected data=%h carry=%b", tag, dout, cout, m_d, m_c);
    end
  endtask

  // one edge; model computed from the requirements
  task automatic cyc(input logic p, input logic s, input logic r, input logic ro,
                     input logic cl, input logic [W-1:0] v, input string tag);
    logic [W-1:0] nd;
    logic         nc;
    pulse = p; step = s; dir = r; rot = ro; clr_n = cl; din = v;
    nd = m_d; nc = m_c;
    if (p) begin
      if (!s) nd = v;
      else if (!r) begin
        nd = (m_d << 1) | (ro ? {{(W-1){1'b0}}, m_c} : '0);
        nc = m_d[W-1];
      end else begin
        nd = (m_d >> 1) | (ro ? {m_d[0], {(W-1){1'b0}}} : '0);
      end
    end
    if (!cl) nc = 1'b0;
    @(negedge clk);
    m_d = nd; m_c = nc;
    check(tag);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;

    // exhaustive sweep: every value, every action, both carry states
    for (int v = 0; v < (1 << W); v++) begin
      for (int op = 0; op < 4; op++) begin
        for (int ci = 0; ci < 2; ci++) begin
          cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8");
          if (ci == 1) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80, "R3");
            cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, "R4");
          end
          cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, v[W-1:0], "R9");
          case (op)
            0: cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, ~v[W-1:0], "R4");
            1: cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, ~v[W-1:0], "R5");
            2: cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, ~v[W-1:0], "R6");
            default: cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, ~v[W-1:0], "R7");
          endcase
          cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, ~v[W-1:0], "R2");
        end
      end
    end

    // clear overrides carry from a left move
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC3, "R3");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R8");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8");
    // full rotate-left circle through carry (W+1 steps returns start)
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, "R3");
    for (int k = 0; k <= W; k++) cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R5");
    // full rotate-right circle (W steps)
    for (int k = 0; k < W; k++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R6");
    // shift right drains to zero, carry kept
    for (int k = 0; k < W; k++) cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, "R7");

    // reset mid-run
    rst_n = 1'b0;
    #1;
    m_d = '0; m_c = 1'b0;
    check("R1");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule